// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregator with End-of-Interrupt Re-arm

This block collects interrupt events from a USB on-the-go controller core and presents them to a host processor as one level interrupt. Events fall into two banks. The endpoint bank holds per-endpoint transmit and receive events. The core bank holds a 9-bit field of USB core events. Each bank keeps a raw source register and an enable mask. Software changes both only through write-1-to-set and write-1-to-clear aliases, and it reads the source AND-ed with the mask from a masked view.

The interrupt line is gated by an armed flag. When the line asserts, the flag clears. After the line drops, it cannot rise again until software writes the end-of-interrupt register. Three more registers sit in the same window:

- a revision register that returns a nonzero constant,
- a control register whose bit 0 pulses a soft-reset request to the controller,
- a status register that reports the drive-VBUS level.

The register port is a plain 32-bit write strobe with an address, and reads are combinational on the same address.

Top module: `usb_irq_agg`

## Requirements
- R1: After reset, every source and mask register reads zero, irq_o is low, soft_rst_o is low and the armed flag is set.
- R2: The revision register at offset 0x00 reads a nonzero constant. Reserved or undefined offsets (for example 0x10 and 0x5C) read zero, and writes to them change no register.
- R3: A write to a set alias (endpoint source 0x24, endpoint mask 0x30, core source 0x44, core mask 0x50) ORs the data into its register. A write to a clear alias (0x28, 0x34, 0x48, 0x54) clears the bits written as one. The aliases themselves read zero.
- R4: The plain registers read as follows: endpoint source at 0x20, endpoint mask at 0x2C, core source at 0x40, core mask at 0x4C. The masked views read source AND mask, at 0x38 for the endpoint bank and at 0x58 for the core bank.
- R5: In the endpoint bank, bits 15:0 are transmit events and bits 31:17 are receive events. Bit 16 never sets and never unmasks. The ep_evt_i bit k maps to register bit k.
- R6: In the core bank, the core_evt_i bit i sets register bit 16+i, so the drive-VBUS event (input bit 8) lands at bit 24. Bits outside 24:16 never set or unmask.
- R7: A hardware event pulse sets its source bit at the clock edge where it is sampled. If a clear-alias write hits the same bit in that cycle, the event wins and the bit ends up set.
- R8: irq_o rises one clock after the edge at which a masked source becomes nonzero while the armed flag is set. irq_o falls one clock after both masked sources become zero.
- R9: A rise of irq_o clears the armed flag. irq_o does not rise again until a write to offset 0x60 re-arms it, and the value written there is ignored.
- R10: A write to control offset 0x04 with data bit 0 set gives a single-cycle soft_rst_o pulse in the following cycle. The control register reads zero.
- R11: The status register at offset 0x08 reads vbus_drive_i in bit 0 and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset, used for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| ep_evt_i | input | 32 | Endpoint event pulses, one per bank bit |
| core_evt_i | input | 9 | Core event pulses |
| vbus_drive_i | input | 1 | Drive-VBUS level, reported in status |
| irq_o | output | 1 | Level interrupt to the host |
| soft_rst_o | output | 1 | Soft-reset request pulse |

## Verification
The timing of each result is fixed:

- Register writes and event pulses show in rdata_o right after the clock edge that samples them, with no extra latency.
- irq_o follows one edge later, because it is registered from the masked sources of the previous cycle.
- soft_rst_o is valid for exactly the one cycle after the control write.

The bench drives every input at the falling edge and keeps a reference model that it advances at each rising edge. It compares irq_o 1 ns after that edge. It compares read data 2 ns after the falling edge that presents the read address, so every check sees the state left by the preceding edge.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;
  localparam int BUS_W    = 32;
  localparam int CORE_LSB = 16;

  localparam logic [7:0] OFF_REV    = 8'h00;
  localparam logic [7:0] OFF_CTRL   = 8'h04;
  localparam logic [7:0] OFF_STAT   = 8'h08;
  localparam logic [7:0] OFF_EP_SRC = 8'h20;
  localparam logic [7:0] OFF_EP_SET = 8'h24;
  localparam logic [7:0] OFF_EP_CLR = 8'h28;
  localparam logic [7:0] OFF_EP_MSK = 8'h2C;
  localparam logic [7:0] OFF_EP_MST = 8'h30;
  localparam logic [7:0] OFF_EP_MCL = 8'h34;
  localparam logic [7:0] OFF_EP_MSD = 8'h38;
  localparam logic [7:0] OFF_CO_SRC = 8'h40;
  localparam logic [7:0] OFF_CO_SET = 8'h44;
  localparam logic [7:0] OFF_CO_CLR = 8'h48;
  localparam logic [7:0] OFF_CO_MSK = 8'h4C;
  localparam logic [7:0] OFF_CO_MST = 8'h50;
  localparam logic [7:0] OFF_CO_MCL = 8'h54;
  localparam logic [7:0] OFF_CO_MSD = 8'h58;
  localparam logic [7:0] OFF_EOI    = 8'h60;

  // Endpoint bank: all bits except 16. Core bank: bits 24:16.
  localparam logic [BUS_W-1:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [BUS_W-1:0] CORE_VALID = 32'h01FF_0000;

  // Set/clear update with hardware events taking priority over clear.
  function automatic logic [BUS_W-1:0] w1_update(
    input logic [BUS_W-1:0] cur,
    input logic [BUS_W-1:0] setv,
    input logic [BUS_W-1:0] clrv,
    input logic [BUS_W-1:0] hw,
    input logic [BUS_W-1:0] valid);
    return (((cur | setv) & ~clrv) | hw) & valid;
  endfunction

  function automatic logic any_masked(
    input logic [BUS_W-1:0] src,
    input logic [BUS_W-1:0] msk);
    return |(src & msk);
  endfunction
endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
  import usb_irq_agg_pkg::*;
#(
  parameter logic [BUS_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_set_i,
  input  logic             src_clr_i,
  input  logic             msk_set_i,
  input  logic             msk_clr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] hw_evt_i,
  output logic [BUS_W-1:0] src_o,
  output logic [BUS_W-1:0] msk_o,
  output logic [BUS_W-1:0] masked_o,
  output logic             pend_o
);
  logic [BUS_W-1:0] src_q, msk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      src_q <= w1_update(src_q, src_set_i ? wdata_i : '0,
                         src_clr_i ? wdata_i : '0, hw_evt_i, VALID);
      msk_q <= w1_update(msk_q, msk_set_i ? wdata_i : '0,
                         msk_clr_i ? wdata_i : '0, '0, VALID);
    end
  end

  assign src_o    = src_q;
  assign msk_o    = msk_q;
  assign masked_o = src_q & msk_q;
  assign pend_o   = any_masked(src_q, msk_q);
endmodule

// File: rtl/usb_irq_eoi_gate.sv
module usb_irq_eoi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic eoi_i,
  output logic irq_o,
  output logic armed_o
);
  logic irq_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq_q   <= pending_i & (irq_q | armed_q);
      armed_q <= eoi_i | (armed_q & ~pending_i);
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_agg_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               CORE_EVT_W = 9,
  parameter logic [BUS_W-1:0] REV_VALUE  = 32'h0001_0A03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BUS_W-1:0]      wdata_i,
  output logic [BUS_W-1:0]      rdata_o,
  input  logic [BUS_W-1:0]      ep_evt_i,
  input  logic [CORE_EVT_W-1:0] core_evt_i,
  input  logic                  vbus_drive_i,
  output logic                  irq_o,
  output logic                  soft_rst_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Named decode events, also used by the checker
  logic ep_set_wr, ep_clr_wr, ep_mset_wr, ep_mclr_wr;
  logic co_set_wr, co_clr_wr, co_mset_wr, co_mclr_wr;
  logic eoi_wr, ctrl_wr;

  assign ep_set_wr  = wr_en_i & hit(addr_i, OFF_EP_SET);
  assign ep_clr_wr  = wr_en_i & hit(addr_i, OFF_EP_CLR);
  assign ep_mset_wr = wr_en_i & hit(addr_i, OFF_EP_MST);
  assign ep_mclr_wr = wr_en_i & hit(addr_i, OFF_EP_MCL);
  assign co_set_wr  = wr_en_i & hit(addr_i, OFF_CO_SET);
  assign co_clr_wr  = wr_en_i & hit(addr_i, OFF_CO_CLR);
  assign co_mset_wr = wr_en_i & hit(addr_i, OFF_CO_MST);
  assign co_mclr_wr = wr_en_i & hit(addr_i, OFF_CO_MCL);
  assign eoi_wr     = wr_en_i & hit(addr_i, OFF_EOI);
  assign ctrl_wr    = wr_en_i & hit(addr_i, OFF_CTRL);

  logic [BUS_W-1:0] core_hw;
  assign core_hw = BUS_W'(core_evt_i) << CORE_LSB;

  logic [BUS_W-1:0] ep_src, ep_msk, ep_masked;
  logic [BUS_W-1:0] core_src, core_msk, core_masked;
  logic             ep_pend, core_pend, pending, armed;

  usb_irq_bank #(.VALID(EP_VALID)) u_ep_bank (
    .clk(clk), .rst_n(rst_n),
    .src_set_i(ep_set_wr), .src_clr_i(ep_clr_wr),
    .msk_set_i(ep_mset_wr), .msk_clr_i(ep_mclr_wr),
    .wdata_i(wdata_i), .hw_evt_i(ep_evt_i),
    .src_o(ep_src), .msk_o(ep_msk), .masked_o(ep_masked), .pend_o(ep_pend)
  );

  usb_irq_bank #(.VALID(CORE_VALID)) u_core_bank (
    .clk(clk), .rst_n(rst_n),
    .src_set_i(co_set_wr), .src_clr_i(co_clr_wr),
    .msk_set_i(co_mset_wr), .msk_clr_i(co_mclr_wr),
    .wdata_i(wdata_i), .hw_evt_i(core_hw),
    .src_o(core_src), .msk_o(core_msk), .masked_o(core_masked), .pend_o(core_pend)
  );

  assign pending = ep_pend | core_pend;

  usb_irq_eoi_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .pending_i(pending), .eoi_i(eoi_wr),
    .irq_o(irq_o), .armed_o(armed)
  );

  logic soft_rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst_q <= 1'b0;
    else        soft_rst_q <= ctrl_wr & wdata_i[0];
  end
  assign soft_rst_o = soft_rst_q;

  always_comb begin
    rdata_o = '0;
    if      (hit(addr_i, OFF_REV))    rdata_o = REV_VALUE;
    else if (hit(addr_i, OFF_STAT))   rdata_o = BUS_W'(vbus_drive_i);
    else if (hit(addr_i, OFF_EP_SRC)) rdata_o = ep_src;
    else if (hit(addr_i, OFF_EP_MSK)) rdata_o = ep_msk;
    else if (hit(addr_i, OFF_EP_MSD)) rdata_o = ep_masked;
    else if (hit(addr_i, OFF_CO_SRC)) rdata_o = core_src;
    else if (hit(addr_i, OFF_CO_MSK)) rdata_o = core_msk;
    else if (hit(addr_i, OFF_CO_MSD)) rdata_o = core_masked;
  end
endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk
  import usb_irq_agg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [BUS_W-1:0] ep_src,
  input logic [BUS_W-1:0] ep_msk,
  input logic [BUS_W-1:0] core_src,
  input logic [BUS_W-1:0] core_msk,
  input logic [BUS_W-1:0] ep_evt_i,
  input logic [BUS_W-1:0] wdata_i,
  input logic             pending,
  input logic             armed,
  input logic             eoi_wr,
  input logic             ctrl_wr,
  input logic             irq_o,
  input logic             soft_rst_o
);
  // R5
  ep_bit16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_src[16] && !ep_msk[16]);

  // R6
  core_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_src | core_msk) & ~CORE_VALID) == '0);

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ep_evt_i) |=> ((ep_src & $past(ep_evt_i & EP_VALID)) == $past(ep_evt_i & EP_VALID)));

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(pending));

  // R9
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(armed));

  // R9
  eoi_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> armed);

  // R10
  soft_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(ctrl_wr && wdata_i[0]));
endmodule

bind usb_irq_agg usb_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ep_src(ep_src), .ep_msk(ep_msk), .core_src(core_src), .core_msk(core_msk),
  .ep_evt_i(ep_evt_i), .wdata_i(wdata_i),
  .pending(pending), .armed(armed), .eoi_wr(eoi_wr), .ctrl_wr(ctrl_wr),
  .irq_o(irq_o), .soft_rst_o(soft_rst_o)
);

// File: tb/usb_irq_agg_bench.sv
`timescale 1ns/1ps
module usb_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] ep_evt_i = '0;
  logic [8:0]  core_evt_i = '0;
  logic        vbus_drive_i = 1'b0;
  logic        irq_o, soft_rst_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_irq_agg u_usb_irq_agg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ep_evt_i(ep_evt_i),
    .core_evt_i(core_evt_i), .vbus_drive_i(vbus_drive_i),
    .irq_o(irq_o), .soft_rst_o(soft_rst_o)
  );

  // Reference model state
  logic [31:0] m_es = '0, m_em = '0, m_cs = '0, m_cm = '0;
  bit m_arm = 1, m_irq = 0;

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h08: return {31'b0, vbus_drive_i};
      8'h20: return m_es;
      8'h2C: return m_em;
      8'h38: return m_es & m_em;
      8'h40: return m_cs;
      8'h4C: return m_cm;
      8'h58: return m_cs & m_cm;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(bit we, logic [7:0] a, logic [31:0] d,
                            logic [31:0] ee, logic [8:0] ce);
    bit pend;
    pend = ((m_es & m_em) != 0) || ((m_cs & m_cm) != 0);
    m_irq = pend && (m_irq || m_arm);
    if (we && a == 8'h60) m_arm = 1;
    else if (pend)        m_arm = 0;
    if (we) begin
      case (a)
        8'h24: m_es = m_es | d;
        8'h28: m_es = m_es & ~d;
        8'h30: m_em = m_em | d;
        8'h34: m_em = m_em & ~d;
        8'h44: m_cs = m_cs | d;
        8'h48: m_cs = m_cs & ~d;
        8'h50: m_cm = m_cm | d;
        8'h54: m_cm = m_cm & ~d;
        default: ;
      endcase
    end
    m_es = (m_es | ee) & 32'hFFFE_FFFF;
    m_em = m_em & 32'hFFFE_FFFF;
    m_cs = (m_cs | {7'b0, ce, 16'b0}) & 32'h01FF_0000;
    m_cm = m_cm & 32'h01FF_0000;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [31:0] d,
                     logic [31:0] ee = '0, logic [8:0] ce = '0);
    @(negedge clk);
    wr_en_i = we; addr_i = a; wdata_i = d; ep_evt_i = ee; core_evt_i = ce;
    @(posedge clk);
    model_step(we, a, d, ee, ce);
    #1;
    wr_en_i = 0; ep_evt_i = '0; core_evt_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en_i = 0; addr_i = a;
    #2 v = rdata_o;
    @(posedge clk);
    model_step(0, a, '0, '0, '0);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  logic [7:0] rd_list [9] = '{8'h08, 8'h20, 8'h2C, 8'h38, 8'h40, 8'h4C, 8'h58, 8'h24, 8'h5C};
  logic [7:0] wr_list [10] = '{8'h24, 8'h28, 8'h30, 8'h34, 8'h44, 8'h48, 8'h50, 8'h54, 8'h60, 8'h10};

  initial begin : stim
    logic [31:0] v;
    int unsigned junk;
    junk = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq_o}, 0);
    chk("R1 soft_rst after reset", {31'b0, soft_rst_o}, 0);
    foreach (rd_list[i]) begin
      rd(rd_list[i], v);
      chk($sformatf("R1 reset read %02h", rd_list[i]), v, exp_rd(rd_list[i]));
    end

    // R2 revision and reserved
    rd(8'h00, v);
    n_chk++;
    if (v == 0) begin n_err++; $display("FAIL R2 revision actual=%08h expected=nonzero", v); end
    cyc(1, 8'h10, 32'hFFFF_FFFF);
    cyc(1, 8'h5C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R2 reserved 10 reads zero", v, 0);
    rd(8'h20, v); chk("R2 reserved write ignored ep src", v, 0);
    rd(8'h4C, v); chk("R2 reserved write ignored core mask", v, 0);

    // R5 endpoint field, R3 set alias
    cyc(1, 8'h24, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R5 ep src bit16 never sets", v, 32'hFFFE_FFFF);
    rd(8'h24, v); chk("R3 set alias reads zero", v, 0);
    // R8 irq timing
    cyc(1, 8'h30, 32'h0001_0001);
    chk("R8 irq not yet after mask edge", {31'b0, irq_o}, 0);
    rd(8'h2C, v); chk("R5 ep mask bit16 never unmasks", v, 32'h0000_0001);
    chk("R8 irq one edge after pending", {31'b0, irq_o}, 1);
    rd(8'h38, v); chk("R4 ep masked view", v, 32'h0000_0001);
    // R3 clear alias drops pending
    cyc(1, 8'h28, 32'h0000_0001);
    chk("R8 irq still high at clear edge", {31'b0, irq_o}, 1);
    rd(8'h20, v); chk("R3 clear alias removes bit", v, 32'hFFFE_FFFE);
    chk("R8 irq falls one edge later", {31'b0, irq_o}, 0);
    // R9 no re-assert without EOI
    cyc(1, 8'h24, 32'h0000_0001);
    idle(4);
    chk("R9 irq stays low without EOI", {31'b0, irq_o}, 0);
    cyc(1, 8'h60, 32'h0000_DEAD);
    chk("R9 irq low at EOI edge", {31'b0, irq_o}, 0);
    idle(1);
    chk("R9 irq rises after EOI", {31'b0, irq_o}, 1);

    // R7 event beats clear in same cycle
    cyc(1, 8'h28, 32'h0000_0008, 32'h0000_0008);
    rd(8'h20, v); chk("R7 event wins over clear", v[3], 1);

    // R6 core field and drive-VBUS event
    cyc(1, 8'h48, 32'hFFFF_FFFF);
    cyc(0, 8'h00, '0, '0, 9'h100);
    rd(8'h40, v); chk("R6 drive-VBUS at bit 24", v, 32'h0100_0000);
    cyc(1, 8'h44, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R6 core src field only", v, 32'h01FF_0000);
    cyc(1, 8'h50, 32'h0103_0005);
    rd(8'h58, v); chk("R4 core masked view", v, 32'h0103_0000);

    // R10 soft reset pulse
    cyc(1, 8'h04, 32'h0000_0001);
    chk("R10 soft reset pulse", {31'b0, soft_rst_o}, 1);
    idle(1);
    chk("R10 soft reset one cycle", {31'b0, soft_rst_o}, 0);
    cyc(1, 8'h04, 32'h0000_0002);
    chk("R10 bit0 clear gives no pulse", {31'b0, soft_rst_o}, 0);
    rd(8'h04, v); chk("R10 control reads zero", v, 0);

    // R11 status
    vbus_drive_i = 1;
    rd(8'h08, v); chk("R11 status vbus high", v, 1);
    vbus_drive_i = 0;
    rd(8'h08, v); chk("R11 status vbus low", v, 0);

    // Random phase against the model
    for (int it = 0; it < 600; it++) begin
      logic [31:0] ee, d;
      logic [8:0]  ce;
      bit we;
      logic [7:0] a, ra;
      we = ($urandom % 3) != 0;
      a  = wr_list[$urandom % 10];
      d  = ($urandom % 2) ? $urandom : (32'h1 << ($urandom % 32));
      ee = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : '0;
      ce = ($urandom % 5 == 0) ? 9'($urandom) : '0;
      vbus_drive_i = $urandom % 2;
      cyc(we, a, d, ee, ce);
      chk("R8 R9 random irq", {31'b0, irq_o}, {31'b0, m_irq});
      ra = rd_list[$urandom % 9];
      rd(ra, v);
      chk($sformatf("R3 R4 random read %02h", ra), v, exp_rd(ra));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule